// File: doc/BRIEF.md
# Screen Tile Binner

This block sorts screen-space triangles into square screen tiles of 32 by 32 pixels. Each triangle arrives in a single valid/ready handshake, carrying three unsigned pixel-coordinate vertices and a primitive index. The block forms the triangle's axis-aligned bounding box and clamps its far corner to the screen. It then walks every tile that the box touches, in row-major order, one tile per clock. For each tile it visits, it appends the primitive index to that tile's list in on-chip storage. Triangles whose box starts beyond the right or bottom screen edge produce no work.

A start-of-frame pulse empties all lists and flags. After the last triangle of a scene, an end-of-scene pulse asks for the coverage map. The block answers with a one-cycle valid strobe once all binning is finished, and the map shows every tile that received at least one primitive. Each list can be read at any time through a combinational read port. A downstream per-tile shading stage uses that port to fetch primitive indices.

Top module: `tile_binner`

## Requirements
- R1: The tile column is floor(x/32) and the tile row is floor(y/32). The tile number is row*TILES_X+column, with TILES_X = SCR_W/32. A box edge at pixel 31 stays in the lower tile, and pixel 32 starts the next tile.
- R2: A triangle is appended to every tile whose column and row fall inside the inclusive range spanned by its bounding box. Before the tile range is formed, the box's maximum x is clamped to SCR_W-1 and its maximum y to SCR_H-1.
- R3: The entries of a tile list are held in arrival order. With rd_tile_i set to a tile, rd_count_o gives the number of stored entries and rd_data_o gives the entry selected by rd_slot_i, where slot 0 is the oldest.
- R4: A triangle is dropped when its minimum x is at least SCR_W or its minimum y is at least SCR_H. A dropped triangle adds no entry, sets no flag, and leaves tri_ready_o high in the cycle after it is accepted.
- R5: After a triangle that covers N tiles is accepted, tri_ready_o stays low for exactly N cycles. The block then accepts the next triangle.
- R6: Each list holds LIST_DEPTH entries. An append to a full list is discarded and sets that tile's bit in ovf_map_o. The tile's coverage bit is still set.
- R7: A frame_start_i pulse clears every list count, every cov_map_o bit and every ovf_map_o bit in the following cycle.
- R8: scene_end_i produces a single-cycle cov_valid_o. It arrives one cycle later if the block is idle, or one cycle after the tile walk ends if it is busy. Bit t of cov_map_o is 1 exactly when tile t received at least one triangle since the last clear.
- R9: After reset, tri_ready_o is high, cov_valid_o is low, both maps are zero and every list count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Clears lists and flags |
| tri_valid_i | input | 1 | Triangle offered |
| tri_ready_o | output | 1 | Triangle can be accepted |
| v0x_i | input | CW | Vertex 0 x |
| v0y_i | input | CW | Vertex 0 y |
| v1x_i | input | CW | Vertex 1 x |
| v1y_i | input | CW | Vertex 1 y |
| v2x_i | input | CW | Vertex 2 x |
| v2y_i | input | CW | Vertex 2 y |
| prim_i | input | PW | Primitive index |
| scene_end_i | input | 1 | Requests the coverage report |
| cov_valid_o | output | 1 | Coverage report strobe |
| cov_map_o | output | NT | Per-tile covered flag |
| ovf_map_o | output | NT | Per-tile list overflow flag |
| rd_tile_i | input | $clog2(NT) | Tile selected for readout |
| rd_slot_i | input | $clog2(LIST_DEPTH) | Entry selected for readout |
| rd_data_o | output | PW | Selected list entry |
| rd_count_o | output | $clog2(LIST_DEPTH+1) | Entries in the selected list |

## Verification
A wrong tile range or a wrong walk position shows up at once on tri_ready_o, because the low time no longer equals the tile count. It also shows as soon as the read port inspects the lists, because entries appear in the wrong tiles or are missing. A list counter that fails to saturate or clear appears as a wrong rd_count_o, a wrong ovf_map_o, or entries out of order. A coverage flag or end-of-scene request that is lost or early is caught on the single cycle in which cov_valid_o fires. It is caught again when the map is compared at that strobe.

// File: rtl/tile_binner_pkg.sv
package tile_binner_pkg;
  localparam int TILE_LOG2 = 5;
  typedef enum logic {W_IDLE, W_WALK} walk_state_e;
endpackage

// File: rtl/tile_binner_bbox.sv
module tile_binner_bbox #(
  parameter int CW    = 10,
  parameter int SCR_W = 256,
  parameter int SCR_H = 128,
  parameter int TXW   = 3,
  parameter int TYW   = 2
) (
  input  logic [CW-1:0]  x0_i, y0_i, x1_i, y1_i, x2_i, y2_i,
  output logic [TXW-1:0] tx_lo_o, tx_hi_o,
  output logic [TYW-1:0] ty_lo_o, ty_hi_o,
  output logic           off_o
);
  import tile_binner_pkg::*;
  logic [CW-1:0] mnx, mny, mxx, mxy, cx, cy;

  always_comb begin
    mnx = x0_i; mxx = x0_i; mny = y0_i; mxy = y0_i;
    if (x1_i < mnx) mnx = x1_i;
    if (x2_i < mnx) mnx = x2_i;
    if (x1_i > mxx) mxx = x1_i;
    if (x2_i > mxx) mxx = x2_i;
    if (y1_i < mny) mny = y1_i;
    if (y2_i < mny) mny = y2_i;
    if (y1_i > mxy) mxy = y1_i;
    if (y2_i > mxy) mxy = y2_i;
    cx = (mxx > CW'(SCR_W - 1)) ? CW'(SCR_W - 1) : mxx;
    cy = (mxy > CW'(SCR_H - 1)) ? CW'(SCR_H - 1) : mxy;
    off_o   = (mnx >= CW'(SCR_W)) || (mny >= CW'(SCR_H));
    tx_lo_o = TXW'(mnx >> TILE_LOG2);
    tx_hi_o = TXW'(cx >> TILE_LOG2);
    ty_lo_o = TYW'(mny >> TILE_LOG2);
    ty_hi_o = TYW'(cy >> TILE_LOG2);
  end
endmodule

// File: rtl/tile_binner_walker.sv
module tile_binner_walker #(
  parameter int TILES_X = 8,
  parameter int TXW     = 3,
  parameter int TYW     = 2,
  parameter int TW      = 5,
  parameter int PW      = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           acc_i,
  input  logic           off_i,
  input  logic [TXW-1:0] tx_lo_i, tx_hi_i,
  input  logic [TYW-1:0] ty_lo_i, ty_hi_i,
  input  logic [PW-1:0]  prim_i,
  output logic           busy_o,
  output logic           wr_en_o,
  output logic [TW-1:0]  wr_tile_o,
  output logic [PW-1:0]  wr_prim_o
);
  import tile_binner_pkg::*;
  walk_state_e st_q;
  logic [TXW-1:0] cx_q, lox_q, hix_q;
  logic [TYW-1:0] cy_q, hiy_q;
  logic [PW-1:0]  prim_q;
  logic           last_x, last_y;

  assign last_x    = (cx_q == hix_q);
  assign last_y    = (cy_q == hiy_q);
  assign busy_o    = (st_q == W_WALK);
  assign wr_en_o   = busy_o;
  assign wr_tile_o = TW'(cy_q) * TW'(TILES_X) + TW'(cx_q);
  assign wr_prim_o = prim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= W_IDLE;
      cx_q <= '0; lox_q <= '0; hix_q <= '0;
      cy_q <= '0; hiy_q <= '0; prim_q <= '0;
    end else if (st_q == W_IDLE) begin
      if (acc_i && !off_i) begin
        st_q  <= W_WALK;
        cx_q  <= tx_lo_i; lox_q <= tx_lo_i; hix_q <= tx_hi_i;
        cy_q  <= ty_lo_i; hiy_q <= ty_hi_i;
        prim_q <= prim_i;
      end
    end else if (last_x) begin
      cx_q <= lox_q;
      if (last_y) st_q <= W_IDLE;
      else        cy_q <= cy_q + 1'b1;
    end else begin
      cx_q <= cx_q + 1'b1;
    end
  end
endmodule

// File: rtl/tile_binner_store.sv
module tile_binner_store #(
  parameter int NT    = 32,
  parameter int DEPTH = 4,
  parameter int PW    = 8,
  parameter int TW    = 5,
  parameter int SW    = 2,
  parameter int CNTW  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_en_i,
  input  logic [TW-1:0]   wr_tile_i,
  input  logic [PW-1:0]   wr_prim_i,
  input  logic [TW-1:0]   rd_tile_i,
  input  logic [SW-1:0]   rd_slot_i,
  output logic [PW-1:0]   rd_data_o,
  output logic [CNTW-1:0] rd_count_o,
  output logic [NT-1:0]   cov_o,
  output logic [NT-1:0]   ovf_o
);
  localparam int AW = $clog2(NT * DEPTH);
  logic [PW-1:0]   mem [NT*DEPTH];
  logic [CNTW-1:0] cnt [NT];
  logic            room;

  assign room = cnt[wr_tile_i] < CNTW'(DEPTH);

  for (genvar t = 0; t < NT; t++) begin : g_tile
    logic hit;
    assign hit = wr_en_i && (wr_tile_i == TW'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt[t] <= '0; cov_o[t] <= 1'b0; ovf_o[t] <= 1'b0;
      end else if (clr_i) begin
        cnt[t] <= '0; cov_o[t] <= 1'b0; ovf_o[t] <= 1'b0;
      end else if (hit) begin
        cov_o[t] <= 1'b1;
        if (cnt[t] < CNTW'(DEPTH)) cnt[t] <= cnt[t] + 1'b1;
        else                       ovf_o[t] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clr_i && room)
      mem[AW'(wr_tile_i) * AW'(DEPTH) + AW'(cnt[wr_tile_i])] <= wr_prim_i;
  end

  assign rd_data_o  = mem[AW'(rd_tile_i) * AW'(DEPTH) + AW'(rd_slot_i)];
  assign rd_count_o = cnt[rd_tile_i];
endmodule

// File: rtl/tile_binner.sv
module tile_binner #(
  parameter int CW         = 10,
  parameter int PW         = 8,
  parameter int SCR_W      = 256,
  parameter int SCR_H      = 128,
  parameter int LIST_DEPTH = 4,
  localparam int TILES_X   = SCR_W / 32,
  localparam int TILES_Y   = SCR_H / 32,
  localparam int NT        = TILES_X * TILES_Y
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            frame_start_i,
  input  logic                            tri_valid_i,
  output logic                            tri_ready_o,
  input  logic [CW-1:0]                   v0x_i,
  input  logic [CW-1:0]                   v0y_i,
  input  logic [CW-1:0]                   v1x_i,
  input  logic [CW-1:0]                   v1y_i,
  input  logic [CW-1:0]                   v2x_i,
  input  logic [CW-1:0]                   v2y_i,
  input  logic [PW-1:0]                   prim_i,
  input  logic                            scene_end_i,
  output logic                            cov_valid_o,
  output logic [NT-1:0]                   cov_map_o,
  output logic [NT-1:0]                   ovf_map_o,
  input  logic [$clog2(NT)-1:0]           rd_tile_i,
  input  logic [$clog2(LIST_DEPTH)-1:0]   rd_slot_i,
  output logic [PW-1:0]                   rd_data_o,
  output logic [$clog2(LIST_DEPTH+1)-1:0] rd_count_o
);
  localparam int TXW  = (TILES_X > 1) ? $clog2(TILES_X) : 1;
  localparam int TYW  = (TILES_Y > 1) ? $clog2(TILES_Y) : 1;
  localparam int TW   = $clog2(NT);
  localparam int SW   = $clog2(LIST_DEPTH);
  localparam int CNTW = $clog2(LIST_DEPTH + 1);

  logic [TXW-1:0] tx_lo, tx_hi;
  logic [TYW-1:0] ty_lo, ty_hi;
  logic           off, busy, wr_en, end_pend_q;
  logic [TW-1:0]  wr_tile;
  logic [PW-1:0]  wr_prim;

  assign tri_ready_o = !busy;

  tile_binner_bbox #(.CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H), .TXW(TXW), .TYW(TYW)) i_bbox (
    .x0_i(v0x_i), .y0_i(v0y_i), .x1_i(v1x_i), .y1_i(v1y_i), .x2_i(v2x_i), .y2_i(v2y_i),
    .tx_lo_o(tx_lo), .tx_hi_o(tx_hi), .ty_lo_o(ty_lo), .ty_hi_o(ty_hi), .off_o(off)
  );

  tile_binner_walker #(.TILES_X(TILES_X), .TXW(TXW), .TYW(TYW), .TW(TW), .PW(PW)) i_walk (
    .clk_i, .rst_ni, .acc_i(tri_valid_i && tri_ready_o), .off_i(off),
    .tx_lo_i(tx_lo), .tx_hi_i(tx_hi), .ty_lo_i(ty_lo), .ty_hi_i(ty_hi), .prim_i,
    .busy_o(busy), .wr_en_o(wr_en), .wr_tile_o(wr_tile), .wr_prim_o(wr_prim)
  );

  tile_binner_store #(.NT(NT), .DEPTH(LIST_DEPTH), .PW(PW), .TW(TW), .SW(SW), .CNTW(CNTW)) i_store (
    .clk_i, .rst_ni, .clr_i(frame_start_i), .wr_en_i(wr_en), .wr_tile_i(wr_tile),
    .wr_prim_i(wr_prim), .rd_tile_i, .rd_slot_i, .rd_data_o, .rd_count_o,
    .cov_o(cov_map_o), .ovf_o(ovf_map_o)
  );

  // hold an end-of-scene request until the tile walk drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_pend_q  <= 1'b0;
      cov_valid_o <= 1'b0;
    end else begin
      end_pend_q  <= (end_pend_q || scene_end_i) && busy;
      cov_valid_o <= (end_pend_q || scene_end_i) && !busy;
    end
  end
endmodule

// File: rtl/tile_binner_chk.sv
module tile_binner_chk #(
  parameter int CW = 10, parameter int SCR_W = 256, parameter int SCR_H = 128,
  parameter int NT = 32, parameter int LIST_DEPTH = 4, parameter int CNTW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_start_i,
  input logic            tri_valid_i,
  input logic            tri_ready_o,
  input logic [CW-1:0]   v0x_i, v1x_i, v2x_i, v0y_i, v1y_i, v2y_i,
  input logic            scene_end_i,
  input logic            cov_valid_o,
  input logic [NT-1:0]   cov_map_o,
  input logic [NT-1:0]   ovf_map_o,
  input logic [CNTW-1:0] rd_count_o
);
  logic all_right, all_below;
  assign all_right = (v0x_i >= CW'(SCR_W)) && (v1x_i >= CW'(SCR_W)) && (v2x_i >= CW'(SCR_W));
  assign all_below = (v0y_i >= CW'(SCR_H)) && (v1y_i >= CW'(SCR_H)) && (v2y_i >= CW'(SCR_H));

  p_drop_offscreen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_valid_i && tri_ready_o && (all_right || all_below)) |=> tri_ready_o);
  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_count_o <= CNTW'(LIST_DEPTH));
  p_ovf_covered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_map_o & ~cov_map_o) == '0);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cov_map_o == '0) && (ovf_map_o == '0));
  p_cov_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ((cov_map_o & $past(cov_map_o)) == $past(cov_map_o)));
  p_report_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scene_end_i && tri_ready_o) |=> cov_valid_o);
endmodule

bind tile_binner tile_binner_chk #(
  .CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H), .NT(NT), .LIST_DEPTH(LIST_DEPTH), .CNTW(CNTW)
) i_chk (
  .clk_i, .rst_ni, .frame_start_i, .tri_valid_i, .tri_ready_o,
  .v0x_i, .v1x_i, .v2x_i, .v0y_i, .v1y_i, .v2y_i,
  .scene_end_i, .cov_valid_o, .cov_map_o, .ovf_map_o, .rd_count_o
);

// File: tb/test_tile_binner.sv
module test_tile_binner;
  localparam int NT = 32, DEPTH = 4, TX = 8;
  logic clk = 0, rst_n = 0, fs = 0, tv = 0, se = 0;
  logic [9:0] x0, y0, x1, y1, x2, y2;
  logic [7:0] pid;
  logic tr, cv;
  logic [NT-1:0] cov, ovf;
  logic [4:0] rt = 0;
  logic [1:0] rs = 0;
  logic [7:0] rd;
  logic [2:0] rc;
  int checks = 0, fails = 0;
  int e_cnt [NT];
  int e_lst [NT][DEPTH];
  logic [NT-1:0] e_cov, e_ovf;
  bit done = 0;

  always #2 clk = ~clk;

  tile_binner i_tile_binner (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .tri_valid_i(tv), .tri_ready_o(tr),
    .v0x_i(x0), .v0y_i(y0), .v1x_i(x1), .v1y_i(y1), .v2x_i(x2), .v2y_i(y2),
    .prim_i(pid), .scene_end_i(se), .cov_valid_o(cv), .cov_map_o(cov), .ovf_map_o(ovf),
    .rd_tile_i(rt), .rd_slot_i(rs), .rd_data_o(rd), .rd_count_o(rc)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < NT; t++) e_cnt[t] = 0;
    e_cov = '0; e_ovf = '0;
  endtask

  task automatic frame_start();
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
    model_clear();
    chk(cov == '0 && ovf == '0, "R7", "maps after clear", {ovf, cov}, 0);
  endtask

  // drive one triangle; returns expected tile count
  task automatic offer(input int ax, ay, bx, by, cx, cy, id, output int n);
    int mnx, mxx, mny, mxy, tx0, tx1, ty0, ty1;
    mnx = ax; mxx = ax; mny = ay; mxy = ay;
    if (bx < mnx) mnx = bx; if (cx < mnx) mnx = cx;
    if (bx > mxx) mxx = bx; if (cx > mxx) mxx = cx;
    if (by < mny) mny = by; if (cy < mny) mny = cy;
    if (by > mxy) mxy = by; if (cy > mxy) mxy = cy;
    if (mxx > 255) mxx = 255;
    if (mxy > 127) mxy = 127;
    n = 0;
    if (mnx < 256 && mny < 128) begin
      tx0 = mnx / 32; tx1 = mxx / 32; ty0 = mny / 32; ty1 = mxy / 32;
      for (int ty = ty0; ty <= ty1; ty++)
        for (int tx = tx0; tx <= tx1; tx++) begin
          int t = ty * TX + tx;
          n++;
          e_cov[t] = 1;
          if (e_cnt[t] < DEPTH) begin e_lst[t][e_cnt[t]] = id; e_cnt[t]++; end
          else e_ovf[t] = 1;
        end
    end
    @(negedge clk);
    x0 = 10'(ax); y0 = 10'(ay); x1 = 10'(bx); y1 = 10'(by); x2 = 10'(cx); y2 = 10'(cy);
    pid = 8'(id); tv = 1;
    @(posedge clk);
    @(negedge clk); tv = 0;
  endtask

  task automatic send(input int ax, ay, bx, by, cx, cy, id, input string req);
    int n, lo;
    offer(ax, ay, bx, by, cx, cy, id, n);
    lo = 0;
    while (!tr && lo < 100) begin lo++; @(negedge clk); end
    chk(lo == n, req, "ready-low cycles", lo, n);
  endtask

  task automatic check_lists(input string req);
    for (int t = 0; t < NT; t++) begin
      rt = 5'(t); #0.1;
      chk(int'(rc) == e_cnt[t], req, $sformatf("count tile %0d", t), rc, e_cnt[t]);
      for (int s = 0; s < e_cnt[t]; s++) begin
        rs = 2'(s); #0.1;
        chk(int'(rd) == e_lst[t][s], req, $sformatf("entry t%0d s%0d", t, s), rd, e_lst[t][s]);
      end
    end
    chk(cov == e_cov, "R8", "cov map", cov, e_cov);
    chk(ovf == e_ovf, "R6", "ovf map", ovf, e_ovf);
  endtask

  task automatic t_reset();
    chk(tr == 1 && cv == 0, "R9", "ready/valid after reset", {tr, cv}, 2);
    chk(cov == '0 && ovf == '0, "R9", "maps after reset", {ovf, cov}, 0);
    check_lists("R9");
  endtask

  task automatic t_bin_basic();
    frame_start();
    send(10, 10, 20, 5, 15, 30, 1, "R1");       // one tile
    send(31, 31, 32, 31, 31, 32, 6, "R1");      // straddles the 31/32 boundary
    send(40, 20, 100, 50, 70, 70, 2, "R5");     // 3x3 tiles
    send(200, 100, 900, 110, 300, 500, 3, "R2"); // clamped far corner
    check_lists("R3");
  endtask

  task automatic t_offscreen();
    send(300, 10, 400, 20, 500, 30, 4, "R4");
    send(10, 200, 20, 300, 5, 129, 5, "R4");
    check_lists("R4");
  endtask

  task automatic t_scene_idle();
    @(negedge clk); se = 1;
    @(negedge clk); se = 0;
    chk(cv == 1, "R8", "strobe one cycle after idle request", cv, 1);
    chk(cov == e_cov, "R8", "map at strobe", cov, e_cov);
    @(negedge clk);
    chk(cv == 0, "R8", "strobe width", cv, 0);
  endtask

  task automatic t_overflow();
    frame_start();
    check_lists("R7");
    for (int i = 0; i < 6; i++) send(100, 40, 120, 50, 110, 60, 10 + i, "R6");
    check_lists("R6");
  endtask

  task automatic t_scene_busy();
    int n, k;
    bit early;
    frame_start();
    offer(40, 20, 100, 50, 70, 70, 20, n);
    se = 1;
    @(negedge clk); se = 0;
    k = 1; early = 0;
    while (!cv && k < 100) begin
      k++; @(negedge clk);
    end
    chk(k == n + 1, "R8", "strobe delay while busy", k, n + 1);
    chk(tr == 1, "R8", "idle at strobe", tr, 1);
    chk(cov == e_cov, "R8", "map at busy strobe", cov, e_cov);
    @(negedge clk);
    chk(cv == 0, "R8", "busy strobe width", cv, 0);
  endtask

  initial begin
    x0 = 0; y0 = 0; x1 = 0; y1 = 0; x2 = 0; y2 = 0; pid = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bin_basic();
    t_offscreen();
    t_scene_idle();
    t_overflow();
    t_scene_busy();
    frame_start();
    check_lists("R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule